// File: doc/BRIEF.md
# 64x64 Crosspoint Configuration Sequencer

This block programs a 64-port crosspoint switch that is built from four 32x32 crosspoint blocks arranged in two rows and two columns. The row of a block is the half of the system inputs it receives (row 0 carries inputs 0..31, row 1 carries inputs 32..63). The column is the half of the system outputs it drives. Each system output is wired to the same local output on the two blocks of its column. Only one of those two drivers may ever be on. The sequencer turns a 64-port connection request into two writes, in a fixed order, to the serially loaded configuration registers of the blocks. The block in the other row is always disabled first, and only then is the block in the row that holds the requested input written with the requested enable.

All four blocks share one serial address line pair and one serial data line pair. Each block has its own active-low load strobe, so the strobe alone picks which block captures the word that was shifted in. Staged writes do not reach the switch until a separate apply command pulses the configure strobe that all four blocks share. Several outputs can therefore be moved at the same time. A single ready signal accepts both connection requests and apply commands. It stays low for the whole of any shifting or strobing.

Top module: `xbar64_cfg_seq`

## Requirements
- R1: While `rst` is high, `blk_rst_n` is low on the next clock, all load strobes and the configure strobe are high, and after release `req_ready` is high. Every block output is then disabled.
- R2: A request for system output O and input I writes local output O[4:0] and local select I[4:0] to block index {I[5],O[5]}. Bit 1 of the index is the row and bit 0 is the column. Load strobe bit b serves block b.
- R3: For each request, the first load goes to block {~I[5],O[5]} with its enable bit 0. The second load goes to block {I[5],O[5]} with enable equal to the request enable.
- R4: Each write shifts 6 rising edges on `sclk_ia` and 5 on `sclk_oa`. The input word goes enable bit first, then select bits 4 down to 0. The output address goes bit 4 first. Each serial clock period is 4 system clocks, 2 low and 2 high. Data holds steady while its clock is high. No serial clock is high while a load strobe is low.
- R5: A load strobe goes low for exactly 2 system clocks, to at most one block at a time, after the last serial clock of the write.
- R6: An accepted apply drives `config_n` low for exactly 2 clocks. It falls only when all load strobes were high in the cycle before, and no load strobe is low while it is low.
- R7: `req_ready` goes low on the clock after acceptance. It stays low for 56 clocks after a connection request and 2 clocks after an apply.
- R8: When a request and an apply are both valid while ready, the request is accepted first. The apply waits for the next ready cycle.
- R9: Two outputs tied to the same system output are never both enabled, neither in the staged registers nor in the active configuration.
- R10: Staged writes have no effect on the active configuration until an apply is accepted.
- R11: A request with enable 0 leaves both tied outputs of that system output disabled after the next apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Connection request valid |
| req_out | input | 6 | System output of the request |
| req_in | input | 6 | System input of the request |
| req_en | input | 1 | Enable for the requested connection |
| apply_valid | input | 1 | Apply command valid |
| req_ready | output | 1 | Accepts a request or an apply when high |
| sclk_oa | output | 1 | Shared serial clock for the output address registers |
| sdat_oa | output | 1 | Shared serial output address bit |
| sclk_ia | output | 1 | Shared serial clock for the input word registers |
| sdat_ia | output | 1 | Shared serial input word bit |
| load_n | output | 4 | Per-block load strobes, active low |
| config_n | output | 1 | Shared configure strobe, active low |
| blk_rst_n | output | 1 | Reset to the four blocks, active low |

## Verification
The bound checker covers the strobe discipline on every cycle. It checks that load strobes are one-hot, that their minimum widths hold, and that the configure strobe is kept apart from the loads. It also checks that the serial clocks are quiet during strobes, that the input data holds while its clock is high, that ready is low during any activity, and the reset values. The mapping to blocks, the disable-before-enable order, and the bit order of the serial words cannot be seen at the pins in a single cycle. The absence of tied-output contention cannot either. Only the bench's model of the four blocks' shift registers, staged registers and active latches shows these, across scenarios that cover both row halves, both column halves, rerouting, disabling, and a request that collides with an apply.

// File: rtl/xsw_pkg.sv
package xsw_pkg;
   localparam int NBLK    = 4;
   localparam int BLK_IDW = 2;

   typedef enum logic [2:0] {
      S_IDLE,
      S_SHIFT,
      S_PRE,
      S_LOAD,
      S_POST,
      S_CFG
   } seq_st_t;

   typedef struct packed {
      logic       en;
      logic [5:0] in_port;
      logic [5:0] out_port;
   } conn_req_t;
endpackage

// File: rtl/xsw_addr_map.sv
// Maps a 64-port request onto a block index, a local output address and
// the serial input word for either pass of the paired write.
module xsw_addr_map #(
   parameter int AW = 6,
   localparam int LW = AW - 1
) (
   input  logic [AW-1:0] out_port,
   input  logic [AW-1:0] in_port,
   input  logic          en,
   input  logic          second_pass,
   output logic [1:0]    blk_sel,
   output logic [LW-1:0] loc_out,
   output logic [AW-1:0] ia_word
);
   logic row_sel;

   // first pass addresses the row that does not hold the input
   assign row_sel = second_pass ? in_port[AW-1] : ~in_port[AW-1];
   assign blk_sel = {row_sel, out_port[AW-1]};
   assign loc_out = out_port[LW-1:0];
   // enable bit leads; only the second pass may carry a one there
   assign ia_word = {second_pass & en, in_port[LW-1:0]};
endmodule

// File: rtl/xsw_bit_timer.sv
// Divides the system clock into serial bit slots and counts bits.
module xsw_bit_timer #(
   parameter int CLK_DIV = 4,
   parameter int NBITS   = 6,
   localparam int PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
   localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          run,
   output logic          sclk,
   output logic [BW-1:0] bit_idx,
   output logic          last
);
   logic [PW-1:0] phase;
   logic          slot_end;

   assign slot_end = (phase == PW'(CLK_DIV - 1));
   assign last     = run && slot_end && (bit_idx == BW'(NBITS - 1));

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         phase   <= '0;
         bit_idx <= '0;
      end else if (slot_end) begin
         phase   <= '0;
         bit_idx <= (bit_idx == BW'(NBITS - 1)) ? '0 : bit_idx + 1'b1;
      end else begin
         phase <= phase + 1'b1;
      end
   end

   generate
      if (CLK_DIV == 2) begin : g_div2
         assign sclk = run & phase[0];
      end else begin : g_divn
         assign sclk = run & (phase >= PW'(CLK_DIV / 2));
      end
   endgenerate
endmodule

// File: rtl/xbar64_cfg_seq.sv
module xbar64_cfg_seq
   import xsw_pkg::*;
#(
   parameter int AW         = 6,
   parameter int CLK_DIV    = 4,
   parameter int STROBE_CYC = 2,
   localparam int LW    = AW - 1,
   localparam int NBITS = AW,
   localparam int BW    = (NBITS > 1) ? $clog2(NBITS) : 1,
   localparam int SW    = $clog2(STROBE_CYC)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_valid,
   input  logic [AW-1:0] req_out,
   input  logic [AW-1:0] req_in,
   input  logic          req_en,
   input  logic          apply_valid,
   output logic          req_ready,
   output logic          sclk_oa,
   output logic          sdat_oa,
   output logic          sclk_ia,
   output logic          sdat_ia,
   output logic [3:0]    load_n,
   output logic          config_n,
   output logic          blk_rst_n
);
   generate
      if (AW != 6) begin : g_bad_aw
         $error("xbar64_cfg_seq: AW must be 6 for a 2x2 array of 32-port blocks");
      end
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("xbar64_cfg_seq: CLK_DIV must be even and at least 2");
      end
      if (STROBE_CYC < 2) begin : g_bad_strobe
         $error("xbar64_cfg_seq: STROBE_CYC must be at least 2");
      end
   endgenerate

   seq_st_t       st;
   logic          second_pass;
   logic [SW-1:0] scnt;
   logic [AW-1:0] lat_out, lat_in;
   logic          lat_en;

   logic [1:0]       blk_sel;
   logic [LW-1:0]    loc_out;
   logic [AW-1:0]    ia_word;
   logic [NBITS-1:0] oa_word;
   logic             sclk_raw;
   logic [BW-1:0]    bit_idx;
   logic             shift_last;
   logic [BW-1:0]    msb_idx;

   xsw_addr_map #(.AW(AW)) u_map (
      .out_port   (lat_out),
      .in_port    (lat_in),
      .en         (lat_en),
      .second_pass(second_pass),
      .blk_sel    (blk_sel),
      .loc_out    (loc_out),
      .ia_word    (ia_word)
   );

   xsw_bit_timer #(.CLK_DIV(CLK_DIV), .NBITS(NBITS)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .run    (st == S_SHIFT),
      .sclk   (sclk_raw),
      .bit_idx(bit_idx),
      .last   (shift_last)
   );

   // output address padded so that bit slot 0 carries a dummy bit
   assign oa_word = {1'b0, loc_out};
   assign msb_idx = BW'(NBITS - 1) - bit_idx;

   always_comb begin
      sdat_ia = 1'b0;
      sdat_oa = 1'b0;
      if (st == S_SHIFT) begin
         sdat_ia = ia_word[msb_idx];
         sdat_oa = oa_word[msb_idx];
      end
   end

   assign sclk_ia   = sclk_raw;
   assign sclk_oa   = sclk_raw && (bit_idx != '0);
   assign config_n  = ~(st == S_CFG);
   assign req_ready = (st == S_IDLE);

   generate
      for (genvar b = 0; b < NBLK; b++) begin : g_load
         assign load_n[b] = ~((st == S_LOAD) && (blk_sel == BLK_IDW'(b)));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         st          <= S_IDLE;
         second_pass <= 1'b0;
         scnt        <= '0;
         lat_out     <= '0;
         lat_in      <= '0;
         lat_en      <= 1'b0;
         blk_rst_n   <= 1'b0;
      end else begin
         blk_rst_n <= 1'b1;
         unique case (st)
            S_IDLE: begin
               scnt        <= '0;
               second_pass <= 1'b0;
               if (req_valid) begin
                  lat_out <= req_out;
                  lat_in  <= req_in;
                  lat_en  <= req_en;
                  st      <= S_SHIFT;
               end else if (apply_valid) begin
                  st <= S_CFG;
               end
            end
            S_SHIFT: begin
               if (shift_last) st <= S_PRE;
            end
            S_PRE: begin
               scnt <= '0;
               st   <= S_LOAD;
            end
            S_LOAD: begin
               if (scnt == SW'(STROBE_CYC - 1)) st <= S_POST;
               else scnt <= scnt + 1'b1;
            end
            S_POST: begin
               scnt <= '0;
               if (!second_pass) begin
                  second_pass <= 1'b1;
                  st          <= S_SHIFT;
               end else begin
                  second_pass <= 1'b0;
                  st          <= S_IDLE;
               end
            end
            S_CFG: begin
               if (scnt == SW'(STROBE_CYC - 1)) st <= S_IDLE;
               else scnt <= scnt + 1'b1;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xsw_seq_chk.sv
module xsw_seq_chk (
   input logic       clk,
   input logic       rst,
   input logic       req_ready,
   input logic       sclk_oa,
   input logic       sclk_ia,
   input logic       sdat_ia,
   input logic [3:0] load_n,
   input logic       config_n,
   input logic       blk_rst_n
);
   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (!blk_rst_n && (&load_n) && config_n))
      else $error("reset state");

   p_oa_inside_ia_r4: assert property (@(posedge clk) disable iff (rst)
      sclk_oa |-> sclk_ia)
      else $error("oa clock outside ia clock");

   p_sdat_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (sclk_ia && $past(sclk_ia)) |-> $stable(sdat_ia))
      else $error("serial data moved while clock high");

   p_quiet_clk_r4: assert property (@(posedge clk) disable iff (rst)
      !(&load_n) |-> (!sclk_ia && !sclk_oa))
      else $error("serial clock during load");

   p_load_onehot_r5: assert property (@(posedge clk) disable iff (rst)
      $onehot0(~load_n))
      else $error("two loads at once");

   p_load_width_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(&load_n) |=> !(&load_n))
      else $error("load strobe too short");

   p_cfg_after_load_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(config_n) |-> $past(&load_n))
      else $error("configure fell with a load low");

   p_cfg_no_load_r6: assert property (@(posedge clk) disable iff (rst)
      !config_n |-> (&load_n))
      else $error("load during configure");

   p_cfg_width_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(config_n) |=> !config_n)
      else $error("configure strobe too short");

   p_busy_r7: assert property (@(posedge clk) disable iff (rst)
      (sclk_ia || !(&load_n) || !config_n) |-> !req_ready)
      else $error("ready during activity");
endmodule

bind xbar64_cfg_seq xsw_seq_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .req_ready(req_ready),
   .sclk_oa  (sclk_oa),
   .sclk_ia  (sclk_ia),
   .sdat_ia  (sdat_ia),
   .load_n   (load_n),
   .config_n (config_n),
   .blk_rst_n(blk_rst_n)
);

// File: tb/xbar64_cfg_seq_test.sv
module xbar64_cfg_seq_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic req_valid = 1'b0, req_en = 1'b0, apply_valid = 1'b0;
   logic [5:0] req_out = '0, req_in = '0;
   logic req_ready, sclk_oa, sdat_oa, sclk_ia, sdat_ia, config_n, blk_rst_n;
   logic [3:0] load_n;

   int checks = 0, failures = 0;

   xbar64_cfg_seq uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_out(req_out),
      .req_in(req_in), .req_en(req_en), .apply_valid(apply_valid),
      .req_ready(req_ready), .sclk_oa(sclk_oa), .sdat_oa(sdat_oa),
      .sclk_ia(sclk_ia), .sdat_ia(sdat_ia), .load_n(load_n),
      .config_n(config_n), .blk_rst_n(blk_rst_n)
   );

   always #10 clk = ~clk;

   // behavioural model of the four blocks
   bit       m_en[4][32];
   int       m_sel[4][32];
   bit       a_en[4][32];
   int       a_sel[4][32];
   bit [5:0] ia_sr;
   bit [4:0] oa_sr;
   bit       p_ia = 0, p_oa = 0;
   bit [3:0] p_ld = 4'hF;
   int       n_ia = 0, n_oa = 0, ld_w = 0, cf_w = 0, busy = 0;
   int       log_blk[$], log_word[$], log_oa[$];
   // expected 64-port map: staged and active
   bit       s_en[64], x_en[64];
   int       s_in[64], x_in[64];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst || !blk_rst_n) begin
         for (int b = 0; b < 4; b++)
            for (int l = 0; l < 32; l++) begin
               m_en[b][l] = 0;
               a_en[b][l] = 0;
            end
         busy = 0;
      end else begin
         chk(req_ready == (busy == 0), "R7 ready", req_ready, busy == 0);
         if (busy > 0) busy--;
         else if (req_valid) busy = 56;
         else if (apply_valid) busy = 2;
         if (sclk_ia && !p_ia) begin ia_sr = {ia_sr[4:0], sdat_ia}; n_ia++; end
         if (sclk_oa && !p_oa) begin oa_sr = {oa_sr[3:0], sdat_oa}; n_oa++; end
         for (int b = 0; b < 4; b++) begin
            if (!load_n[b]) begin
               if (p_ld[b]) begin
                  log_blk.push_back(b);
                  log_word.push_back(int'(ia_sr));
                  log_oa.push_back(int'(oa_sr));
               end
               m_en[b][oa_sr]  = ia_sr[5];
               m_sel[b][oa_sr] = int'(ia_sr[4:0]);
            end
         end
         if (load_n != 4'hF) ld_w++;
         else if (ld_w > 0) begin chk(ld_w == 2, "R5 load width", ld_w, 2); ld_w = 0; end
         if (!config_n) begin
            cf_w++;
            a_en  = m_en;
            a_sel = m_sel;
         end else if (cf_w > 0) begin
            chk(cf_w == 2, "R6 config width", cf_w, 2);
            cf_w = 0;
         end
         begin
            int both = 0;
            for (int c = 0; c < 2; c++)
               for (int l = 0; l < 32; l++)
                  if ((m_en[c][l] && m_en[2+c][l]) || (a_en[c][l] && a_en[2+c][l])) both++;
            chk(both == 0, "R9 tied outputs both enabled", both, 0);
         end
      end
      p_ia = sclk_ia; p_oa = sclk_oa; p_ld = load_n;
   end

   task automatic verify_active(input string tag);
      int bad = 0, first = -1;
      for (int o = 0; o < 64; o++) begin
         int c = o / 32, l = o % 32;
         bit ok;
         if (x_en[o]) begin
            int r = x_in[o] / 32;
            ok = a_en[2*r+c][l] && (a_sel[2*r+c][l] == x_in[o] % 32) && !a_en[2*(1-r)+c][l];
         end else begin
            ok = !a_en[c][l] && !a_en[2+c][l];
         end
         if (!ok) begin bad++; if (first < 0) first = o; end
      end
      chk(bad == 0, {tag, " active map (actual=mismatching outputs, first listed)"}, bad, 0);
      if (bad != 0) $display("  first mismatching output %0d", first);
   endtask

   task automatic wait_ready();
      while (!req_ready) begin @(posedge clk); #2; end
   endtask

   task automatic send_req(input int o, input int i, input bit e);
      int sel_b = (i / 32) * 2 + o / 32;
      int oth_b = (1 - i / 32) * 2 + o / 32;
      wait_ready();
      log_blk.delete(); log_word.delete(); log_oa.delete();
      n_ia = 0; n_oa = 0;
      req_out = 6'(o); req_in = 6'(i); req_en = e; req_valid = 1;
      @(posedge clk); #2;
      req_valid = 0;
      wait_ready();
      s_en[o] = e; s_in[o] = i;
      chk(log_blk.size() == 2, "R3 load count", log_blk.size(), 2);
      if (log_blk.size() == 2) begin
         chk(log_blk[0] == oth_b, "R3 first load block", log_blk[0], oth_b);
         chk(log_word[0] == (i % 32), "R3 first word disables", log_word[0], i % 32);
         chk(log_blk[1] == sel_b, "R2 second load block", log_blk[1], sel_b);
         chk(log_word[1] == (int'(e) * 32 + i % 32), "R2 second word", log_word[1], int'(e) * 32 + i % 32);
         chk(log_oa[0] == o % 32 && log_oa[1] == o % 32, "R2 local output", log_oa[1], o % 32);
      end
      chk(n_ia == 12, "R4 ia clock edges", n_ia, 12);
      chk(n_oa == 10, "R4 oa clock edges", n_oa, 10);
   endtask

   task automatic do_apply();
      wait_ready();
      apply_valid = 1;
      @(posedge clk); #2;
      apply_valid = 0;
      chk(config_n == 0, "R6 config low after apply", config_n, 0);
      wait_ready();
      x_en = s_en; x_in = s_in;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=50000 expected<50000");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #2;
      chk(blk_rst_n == 0, "R1 block reset low", blk_rst_n, 0);
      chk(load_n == 4'hF && config_n == 1, "R1 strobes high", int'({load_n, config_n}), 31);
      rst = 0;
      @(posedge clk); #2;
      chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
      chk(blk_rst_n == 1, "R1 block reset released", blk_rst_n, 1);
      verify_active("R1");

      // row 1 input, column 0 output
      send_req(5, 40, 1);
      verify_active("R10 before apply");
      do_apply();
      verify_active("R2");

      // column 1, row 0
      send_req(37, 3, 1);
      // request and apply together: request goes first
      wait_ready();
      req_out = 6'd63; req_in = 6'd63; req_en = 1; req_valid = 1; apply_valid = 1;
      @(posedge clk); #2;
      req_valid = 0;
      chk(req_ready == 0 && config_n == 1, "R8 request before apply", config_n, 1);
      s_en[63] = 1; s_in[63] = 63;
      wait_ready();
      verify_active("R10 staged only");
      @(posedge clk); #2;
      apply_valid = 0;
      chk(config_n == 0, "R8 deferred apply runs", config_n, 0);
      wait_ready();
      x_en = s_en; x_in = s_in;
      verify_active("R8");

      // reroute output 5 from row 1 to row 0
      send_req(5, 7, 1);
      do_apply();
      verify_active("R9 reroute");

      // disconnect output 37
      send_req(37, 3, 0);
      do_apply();
      verify_active("R11");
      chk(a_en[1][5] == 0 && a_en[3][5] == 0, "R11 both tied disabled", int'(a_en[1][5]), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule